// File: doc/BRIEF.md
# Circular Request List Pointer Controller

This block manages two circular lists of request units: an inbound list that the host fills and a completion list that the controller fills. The host stores each unit (a request address and a request size) through a small entry-write port. It then publishes the index of the newest filled unit by writing the inbound write pointer. The controller walks the inbound list from its own consumer pointer up to that index. It hands each unit to a downstream processing path with a valid/ready handshake.

When the processing path reports a completion, the controller writes the completed request index, OR-ed with a fixed marker pattern, into the next unit of the completion list. It then moves the copy pointer to that unit and sets an interrupt cause bit. The copy pointer is also driven out continuously as a shadow value. The host compares it with its own saved read pointer N: when they differ, unit N+1 (modulo the count) is the next one to read. The host reads completion units through a registered read port.

Both lists wrap at a programmable request count. Every pointer names the last unit used, not the next free one, so equal pointers mean an empty list. A count of C allows at most C-1 outstanding inbound units.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: After reset the count register reads MAX_UNITS, and the inbound write pointer, the consumer pointer and the copy pointer are all MAX_UNITS-1. The cause bit, the enable bit, `irq` and `req_valid` are all 0.
- R2: A write to offset 0x0C takes the count from bits [CNT_W-1:0]. The write is accepted only for values 1..MAX_UNITS and is ignored otherwise. An accepted write sets the inbound write pointer, the consumer pointer and the copy pointer to count-1.
- R3: A write to offset 0x08 takes the inbound write pointer from bits [IDX_W-1:0]. The write is accepted only when the value is below the count and is ignored otherwise.
- R4: While the consumer pointer differs from the inbound write pointer, the controller presents unit (consumer+1) mod count on `req_idx`, with the address and size last stored for that unit. Units come out in ring order. Nothing is presented when the two pointers are equal.
- R5: Once `req_valid` is high, it stays high with `req_idx`, `req_addr` and `req_size` unchanged until `req_ready` is seen. The handshake advances the consumer pointer to `req_idx`.
- R6: Each `cpl_valid` cycle moves the copy pointer to (copy+1) mod count and writes OB_MARK | `cpl_tag` into that unit. The copy pointer is seen on `shadow_ptr` after that edge and reads at offset 0x20.
- R7: Bit 0 at offset 0x24 is the cause bit. Each completion sets it, and writing 1 to it clears it. When a completion and a clear arrive in the same cycle, the bit ends up set. Writing 0 leaves it unchanged.
- R8: `irq` equals the cause bit AND the enable bit (offset 0x28, bit 0), one cycle after them.
- R9: `ob_rd_data` returns the completion unit selected by `ob_rd_idx`, one cycle later.
- R10: The six base words at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read back as written. Register reads return data one cycle after `reg_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| ent_we | input | 1 | Inbound unit write strobe |
| ent_idx | input | IDX_W | Inbound unit index to write |
| ent_addr | input | ADDR_W | Request address for the unit |
| ent_size | input | SIZE_W | Request size for the unit |
| req_valid | output | 1 | A request unit is presented |
| req_ready | input | 1 | Processing path accepts the unit |
| req_idx | output | IDX_W | Index of the presented unit |
| req_addr | output | ADDR_W | Address of the presented unit |
| req_size | output | SIZE_W | Size of the presented unit |
| cpl_valid | input | 1 | A completion is reported this cycle |
| cpl_tag | input | IDX_W | Request index being completed |
| ob_rd_idx | input | IDX_W | Completion unit to read |
| ob_rd_data | output | OB_W | Completion unit contents |
| shadow_ptr | output | IDX_W | Shadow of the copy pointer |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps every count from 1 to 8 on an 8-unit build. It drives each count around the ring more than once, so a wrap computed against the maximum size rather than the programmed count would present or write the wrong index. Count 1 is a corner of its own: the write pointer can never move away from the consumer pointer, so a design that treats equal pointers as a full ring would emit a request.

The bench also holds `req_ready` low to catch a presentation that drops or changes before the handshake. It writes out-of-range count and pointer values, which a careless decoder would accept and so corrupt the ring. It issues a completion in the same cycle as a cause clear, where a clear-priority design would lose an interrupt.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam logic [7:0] A_IB_LO  = 8'h00;
  localparam logic [7:0] A_IB_HI  = 8'h04;
  localparam logic [7:0] A_WPTR   = 8'h08;
  localparam logic [7:0] A_CFG    = 8'h0C;
  localparam logic [7:0] A_OB_LO  = 8'h10;
  localparam logic [7:0] A_OB_HI  = 8'h14;
  localparam logic [7:0] A_SH_LO  = 8'h18;
  localparam logic [7:0] A_SH_HI  = 8'h1C;
  localparam logic [7:0] A_CPTR   = 8'h20;
  localparam logic [7:0] A_CAUSE  = 8'h24;
  localparam logic [7:0] A_IEN    = 8'h28;

  localparam int NUM_BASE = 6;

  // maps a base-word offset to its storage slot; returns NUM_BASE when unmapped
  function automatic int base_slot(logic [7:0] a);
    case (a)
      A_IB_LO: return 0;
      A_IB_HI: return 1;
      A_OB_LO: return 2;
      A_OB_HI: return 3;
      A_SH_LO: return 4;
      A_SH_HI: return 5;
      default: return NUM_BASE;
    endcase
  endfunction
endpackage

// File: rtl/rpc_ram.sv
module rpc_ram #(
  parameter int W = 32,
  parameter int D = 256,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rpc_regs.sv
module rpc_regs
  import rpc_pkg::*;
#(
  parameter int MAX_UNITS = 256,
  localparam int IDX_W = $clog2(MAX_UNITS),
  localparam int CNT_W = $clog2(MAX_UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [CNT_W-1:0] count_o,
  output logic [IDX_W-1:0] wptr_o,
  output logic             cfg_load_o,
  output logic [IDX_W-1:0] cfg_last_o,
  output logic             en_o,
  output logic             w1c_o,
  input  logic [IDX_W-1:0] copy_ptr_i,
  input  logic             cause_i
);
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] wptr_q;
  logic             en_q;
  logic [31:0]      base_q [NUM_BASE];

  logic [CNT_W-1:0] cfg_val;
  logic [IDX_W-1:0] wp_val;
  logic             cfg_ok, wp_ok;
  int               wslot, rslot;

  assign cfg_val    = reg_wdata[CNT_W-1:0];
  assign wp_val     = reg_wdata[IDX_W-1:0];
  assign cfg_ok     = (cfg_val != '0) && (cfg_val <= CNT_W'(MAX_UNITS));
  assign wp_ok      = (CNT_W'(wp_val) < count_q);
  assign cfg_load_o = reg_wr && (reg_addr == A_CFG) && cfg_ok;
  assign cfg_last_o = IDX_W'(cfg_val - CNT_W'(1));
  assign w1c_o      = reg_wr && (reg_addr == A_CAUSE) && reg_wdata[0];
  assign wslot      = base_slot(reg_addr);
  assign rslot      = base_slot(reg_addr);

  assign count_o = count_q;
  assign wptr_o  = wptr_q;
  assign en_o    = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= CNT_W'(MAX_UNITS);
      wptr_q  <= IDX_W'(MAX_UNITS - 1);
      en_q    <= 1'b0;
    end else if (reg_wr) begin
      if (cfg_load_o) begin
        count_q <= cfg_val;
        wptr_q  <= cfg_last_o;
      end
      if (reg_addr == A_WPTR && wp_ok) wptr_q <= wp_val;
      if (reg_addr == A_IEN) en_q <= reg_wdata[0];
    end
  end

  generate
    for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
      always_ff @(posedge clk) begin
        if (rst) base_q[g] <= '0;
        else if (reg_wr && wslot == g) base_q[g] <= reg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (rslot < NUM_BASE) begin
        reg_rdata <= base_q[rslot];
      end else begin
        case (reg_addr)
          A_WPTR:  reg_rdata <= 32'(wptr_q);
          A_CFG:   reg_rdata <= 32'(count_q);
          A_CPTR:  reg_rdata <= 32'(copy_ptr_i);
          A_CAUSE: reg_rdata <= 32'(cause_i);
          A_IEN:   reg_rdata <= 32'(en_q);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rpc_ib_engine.sv
module rpc_ib_engine #(
  parameter int MAX_UNITS = 256,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  localparam int IDX_W = $clog2(MAX_UNITS),
  localparam int CNT_W = $clog2(MAX_UNITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic [IDX_W-1:0]  wptr,
  input  logic              cfg_load,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [SIZE_W-1:0] ent_size,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_idx,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SIZE_W-1:0] req_size
);
  localparam int UW = ADDR_W + SIZE_W;

  logic [IDX_W-1:0] rd_q, nxt;
  logic             vld_q, fire;
  logic [UW-1:0]    unit_q;

  assign nxt  = ((CNT_W'(rd_q) + CNT_W'(1)) == count) ? '0 : IDX_W'(rd_q + IDX_W'(1));
  assign fire = !vld_q && (rd_q != wptr) && !cfg_load;

  rpc_ram #(.W(UW), .D(MAX_UNITS)) u_ram (
    .clk   (clk),
    .we    (ent_we),
    .waddr (ent_idx),
    .wdata ({ent_addr, ent_size}),
    .re    (fire),
    .raddr (nxt),
    .rdata (unit_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= IDX_W'(MAX_UNITS - 1);
      vld_q   <= 1'b0;
      req_idx <= '0;
    end else if (cfg_load) begin
      rd_q  <= cfg_last;
      vld_q <= 1'b0;
    end else if (fire) begin
      vld_q   <= 1'b1;
      req_idx <= nxt;
    end else if (vld_q && req_ready) begin
      vld_q <= 1'b0;
      rd_q  <= req_idx;
    end
  end

  assign req_valid = vld_q;
  assign req_addr  = unit_q[UW-1:SIZE_W];
  assign req_size  = unit_q[SIZE_W-1:0];
endmodule

// File: rtl/rpc_ob_engine.sv
module rpc_ob_engine #(
  parameter int MAX_UNITS = 256,
  parameter int OB_W = 32,
  parameter logic [31:0] OB_MARK = 32'hC000_0000,
  localparam int IDX_W = $clog2(MAX_UNITS),
  localparam int CNT_W = $clog2(MAX_UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             cfg_load,
  input  logic [IDX_W-1:0] cfg_last,
  input  logic             cpl_valid,
  input  logic [IDX_W-1:0] cpl_tag,
  input  logic             w1c,
  input  logic             en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [OB_W-1:0]  rd_data,
  output logic [IDX_W-1:0] copy_ptr,
  output logic             cause,
  output logic             irq
);
  logic [IDX_W-1:0] cp_q, nxt;
  logic             cause_q, irq_q, do_cpl;

  assign nxt    = ((CNT_W'(cp_q) + CNT_W'(1)) == count) ? '0 : IDX_W'(cp_q + IDX_W'(1));
  assign do_cpl = cpl_valid && !cfg_load;

  rpc_ram #(.W(OB_W), .D(MAX_UNITS)) u_ram (
    .clk   (clk),
    .we    (do_cpl),
    .waddr (nxt),
    .wdata (OB_W'(OB_MARK) | OB_W'(cpl_tag)),
    .re    (1'b1),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_q    <= IDX_W'(MAX_UNITS - 1);
      cause_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (cfg_load)    cp_q <= cfg_last;
      else if (do_cpl) cp_q <= nxt;
      if (do_cpl)      cause_q <= 1'b1;
      else if (w1c)    cause_q <= 1'b0;
      irq_q <= cause_q && en;
    end
  end

  assign copy_ptr = cp_q;
  assign cause    = cause_q;
  assign irq      = irq_q;
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl #(
  parameter int MAX_UNITS = 256,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int OB_W = 32,
  parameter logic [31:0] OB_MARK = 32'hC000_0000,
  localparam int IDX_W = $clog2(MAX_UNITS),
  localparam int CNT_W = $clog2(MAX_UNITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [SIZE_W-1:0] ent_size,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_idx,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SIZE_W-1:0] req_size,
  input  logic              cpl_valid,
  input  logic [IDX_W-1:0]  cpl_tag,
  input  logic [IDX_W-1:0]  ob_rd_idx,
  output logic [OB_W-1:0]   ob_rd_data,
  output logic [IDX_W-1:0]  shadow_ptr,
  output logic              irq
);
  logic [CNT_W-1:0] count_w;
  logic [IDX_W-1:0] wptr_w, cfg_last_w, copy_w;
  logic             cfg_load_w, en_w, w1c_w, cause_w;

  rpc_regs #(.MAX_UNITS(MAX_UNITS)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .count_o    (count_w),
    .wptr_o     (wptr_w),
    .cfg_load_o (cfg_load_w),
    .cfg_last_o (cfg_last_w),
    .en_o       (en_w),
    .w1c_o      (w1c_w),
    .copy_ptr_i (copy_w),
    .cause_i    (cause_w)
  );

  rpc_ib_engine #(.MAX_UNITS(MAX_UNITS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ib (
    .clk       (clk),
    .rst       (rst),
    .count     (count_w),
    .wptr      (wptr_w),
    .cfg_load  (cfg_load_w),
    .cfg_last  (cfg_last_w),
    .ent_we    (ent_we),
    .ent_idx   (ent_idx),
    .ent_addr  (ent_addr),
    .ent_size  (ent_size),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_idx   (req_idx),
    .req_addr  (req_addr),
    .req_size  (req_size)
  );

  rpc_ob_engine #(.MAX_UNITS(MAX_UNITS), .OB_W(OB_W), .OB_MARK(OB_MARK)) u_ob (
    .clk       (clk),
    .rst       (rst),
    .count     (count_w),
    .cfg_load  (cfg_load_w),
    .cfg_last  (cfg_last_w),
    .cpl_valid (cpl_valid),
    .cpl_tag   (cpl_tag),
    .w1c       (w1c_w),
    .en        (en_w),
    .rd_idx    (ob_rd_idx),
    .rd_data   (ob_rd_data),
    .copy_ptr  (copy_w),
    .cause     (cause_w),
    .irq       (irq)
  );

  assign shadow_ptr = copy_w;
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] req_idx,
  input logic             cpl_valid,
  input logic             cfg_load,
  input logic             cause,
  input logic             en,
  input logic             irq,
  input logic [IDX_W-1:0] shadow_ptr,
  input logic [CNT_W-1:0] count
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready && !cfg_load |=> req_valid && $stable(req_idx));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (CNT_W'(req_idx) < count));

  assert_copy_range_R6: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(shadow_ptr) < count);

  assert_cause_set_R7: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !cfg_load |=> cause);

  assert_irq_on_R8: assert property (@(posedge clk) disable iff (rst)
    cause && en |=> irq);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    !(cause && en) |=> !irq);
endmodule

bind ring_ptr_ctrl rpc_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_idx    (req_idx),
  .cpl_valid  (cpl_valid),
  .cfg_load   (cfg_load_w),
  .cause      (cause_w),
  .en         (en_w),
  .irq        (irq),
  .shadow_ptr (shadow_ptr),
  .count      (count_w)
);

// File: tb/ring_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module ring_ptr_ctrl_tb;
  localparam int MAXU = 8;
  localparam int IW = 3;
  localparam logic [31:0] OBM = 32'hC000_0000;
  localparam logic [7:0] A_WPTR = 8'h08, A_CFG = 8'h0C, A_CPTR = 8'h20,
                         A_CAUSE = 8'h24, A_IEN = 8'h28;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, reg_wr, reg_rd, ent_we, req_valid, req_ready, cpl_valid, irq;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, ent_addr, req_addr, ob_rd_data;
  logic [15:0] ent_size, req_size;
  logic [IW-1:0] ent_idx, req_idx, cpl_tag, ob_rd_idx, shadow_ptr;

  ring_ptr_ctrl #(.MAX_UNITS(MAXU), .OB_MARK(OBM)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_we(ent_we), .ent_idx(ent_idx),
    .ent_addr(ent_addr), .ent_size(ent_size), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_addr(req_addr), .req_size(req_size), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .ob_rd_idx(ob_rd_idx), .ob_rd_data(ob_rd_data),
    .shadow_ptr(shadow_ptr), .irq(irq));

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic put_ent(int idx, logic [31:0] a, logic [15:0] s);
    @(negedge clk); ent_we = 1'b1; ent_idx = IW'(idx); ent_addr = a; ent_size = s;
    @(negedge clk); ent_we = 1'b0;
  endtask

  task automatic cpl(int tag);
    @(negedge clk); cpl_valid = 1'b1; cpl_tag = IW'(tag);
    @(negedge clk); cpl_valid = 1'b0;
  endtask

  task automatic ob_rd(int idx, output logic [31:0] d);
    @(negedge clk); ob_rd_idx = IW'(idx);
    @(negedge clk); d = ob_rd_data;
  endtask

  function automatic logic [31:0] addr_of(int idx, int rnd);
    return 32'h4000_0000 + 32'(idx * 64) + 32'(rnd * 4096);
  endfunction

  function automatic logic [15:0] size_of(int idx, int rnd);
    return 16'(idx * 5 + rnd + 1);
  endfunction

  // waits for a presented unit (req_ready assumed high) and checks its fields
  task automatic take(int idx, logic [31:0] a, logic [15:0] s);
    for (int n = 0; n < 40 && !req_valid; n++) @(negedge clk);
    chk("R4 req_valid", 32'(req_valid), 32'd1);
    chk("R4 req_idx", 32'(req_idx), 32'(idx));
    chk("R4 req_addr", req_addr, a);
    chk("R4 req_size", 32'(req_size), 32'(s));
    @(negedge clk);
  endtask

  logic [31:0] v;
  int e, cp, tag;

  initial begin
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    ent_we = 0; ent_idx = 0; ent_addr = 0; ent_size = 0; req_ready = 1'b1;
    cpl_valid = 0; cpl_tag = 0; ob_rd_idx = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 shadow", 32'(shadow_ptr), MAXU - 1);
    rd(A_CFG, v);   chk("R1 count", v, MAXU);
    rd(A_WPTR, v);  chk("R1 wptr", v, MAXU - 1);
    rd(A_CPTR, v);  chk("R1 copy", v, MAXU - 1);
    rd(A_CAUSE, v); chk("R1 cause", v, 0);
    rd(A_IEN, v);   chk("R1 enable", v, 0);

    // sweep every count: ring order, wrap, completion placement
    for (int c = 1; c <= MAXU; c++) begin
      wr(A_CFG, 32'(c));
      rd(A_CFG, v);  chk("R2 count", v, 32'(c));
      rd(A_WPTR, v); chk("R2 wptr reinit", v, 32'(c - 1));
      rd(A_CPTR, v); chk("R2 copy reinit", v, 32'(c - 1));
      chk("R2 shadow reinit", 32'(shadow_ptr), 32'(c - 1));
      if (c == 1) begin
        put_ent(0, addr_of(0, 0), size_of(0, 0));
        wr(A_WPTR, 0);
        repeat (6) @(negedge clk);
        chk("R4 empty at count 1", 32'(req_valid), 0);
      end else begin
        e = c - 1;
        for (int k = 0; k < c + 2; k++) begin
          e = (e + 1) % c;
          put_ent(e, addr_of(e, k), size_of(e, k));
          wr(A_WPTR, 32'(e));
          take(e, addr_of(e, k), size_of(e, k));
        end
        repeat (4) @(negedge clk);
        chk("R4 idle when caught up", 32'(req_valid), 0);
        cp = c - 1;
        for (int k = 0; k < c + 1; k++) begin
          tag = (k * 3 + 1) % c;
          cpl(tag);
          cp = (cp + 1) % c;
          chk("R6 shadow advance", 32'(shadow_ptr), 32'(cp));
          ob_rd(cp, v);
          chk("R9 R6 outbound unit", v, OBM | 32'(tag));
        end
        rd(A_CPTR, v); chk("R6 copy register", v, 32'(cp));
      end
    end

    // R4 batch posting, count 5
    wr(A_CFG, 5);
    for (int i = 0; i < 3; i++) put_ent(i, addr_of(i, 7), size_of(i, 7));
    wr(A_WPTR, 2);
    for (int i = 0; i < 3; i++) take(i, addr_of(i, 7), size_of(i, 7));

    // R5 hold under back-pressure
    put_ent(3, addr_of(3, 9), size_of(3, 9));
    req_ready = 1'b0;
    wr(A_WPTR, 3);
    repeat (4) @(negedge clk);
    chk("R5 valid held", 32'(req_valid), 1);
    chk("R5 idx held", 32'(req_idx), 3);
    repeat (3) @(negedge clk);
    chk("R5 still held", 32'(req_valid), 1);
    chk("R5 addr held", req_addr, addr_of(3, 9));
    req_ready = 1'b1;
    @(negedge clk);
    chk("R5 released after ready", 32'(req_valid), 0);

    // R3 out-of-range pointer ignored
    wr(A_WPTR, 6); rd(A_WPTR, v); chk("R3 wptr 6 ignored", v, 3);
    wr(A_WPTR, 7); rd(A_WPTR, v); chk("R3 wptr 7 ignored", v, 3);
    repeat (4) @(negedge clk);
    chk("R3 no request from ignored write", 32'(req_valid), 0);

    // R2 illegal counts ignored
    wr(A_CFG, 0); rd(A_CFG, v); chk("R2 count 0 ignored", v, 5);
    wr(A_CFG, 9); rd(A_CFG, v); chk("R2 count 9 ignored", v, 5);
    rd(A_CPTR, v); chk("R2 copy untouched", v, 4);

    // R7 / R8 cause and interrupt
    wr(A_CAUSE, 1); rd(A_CAUSE, v); chk("R7 cleared", v, 0);
    cpl(1);
    rd(A_CAUSE, v); chk("R7 set by completion", v, 1);
    chk("R8 masked irq", 32'(irq), 0);
    wr(A_IEN, 1);
    repeat (2) @(negedge clk);
    chk("R8 irq raised", 32'(irq), 1);
    wr(A_CAUSE, 0); rd(A_CAUSE, v); chk("R7 write 0 keeps", v, 1);
    wr(A_CAUSE, 1);
    repeat (2) @(negedge clk);
    chk("R8 irq dropped", 32'(irq), 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CAUSE; reg_wdata = 1; cpl_valid = 1'b1; cpl_tag = 2;
    @(negedge clk);
    reg_wr = 1'b0; cpl_valid = 1'b0;
    rd(A_CAUSE, v); chk("R7 set wins over clear", v, 1);
    chk("R8 irq after collision", 32'(irq), 1);

    // R10 base words and unmapped read
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i < 2) ? 8'(i * 4) : 8'(16 + (i - 2) * 4);
      wr(a, 32'hA55A_0000 ^ 32'(i * 32'h0101_0101));
    end
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i < 2) ? 8'(i * 4) : 8'(16 + (i - 2) * 4);
      rd(a, v);
      chk("R10 base readback", v, 32'hA55A_0000 ^ 32'(i * 32'h0101_0101));
    end
    rd(8'h3C, v); chk("R10 unmapped", v, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R4 flow hung got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule